// File: doc/BRIEF.md
# Mode-Pin Root Clock Selector

This block turns a single fast input clock into two derived timing strobes whose sources are fixed by three mode pins. The first strobe, the system enable, runs at the full input rate or at half of it. The second strobe, the reference tick, comes from one of three sources: a slow external pin (nominally 32.768 kHz), the input divided by 1024, or the input divided by 2048. Every derived output is a one-cycle enable in the input clock domain. None of them is a generated clock.

The mode pins are sampled on every clock edge while reset is asserted. The last sample is then held for as long as reset stays released. Mode bit 1 selects the system rate. Mode bit 2, together with bit 1, selects the reference source. Mode bit 0 tells an oscillator from a crystal. It is reported in the status word but affects no selection. The slow pin passes through a synchroniser and a rising-edge detector before it is used.

Top module: `rootclk_mode_sel`

## Requirements
- R1: While `rst_n` is low, `sys_en` and `ref_tick` are both 0.
- R2: `status[2:0]` equals the value of `mode_pins` at the last clock edge with `rst_n` low, and changes of `mode_pins` after release leave it unchanged.
- R3: With latched mode bit 1 clear, `sys_en` is 1 on every cycle after reset release.
- R4: With latched mode bit 1 set, `sys_en` is 1 after the odd-numbered rising edges following release (the 1st, 3rd and so on) and 0 after the even-numbered ones.
- R5: With latched mode bit 2 clear, `ref_tick` is a single-cycle pulse for each rising edge of `slow_pin`. It is 1 after edge n exactly when `slow_pin` was 1 at edge n-1 and 0 at edge n-2. `status[4:3]` is 0 in this mode.
- R6: With latched bits 2 and 1 equal to 1 and 0, `ref_tick` is 1 exactly after edges n with n mod 1024 = 1023 (n counted from release), and `status[4:3]` is 1.
- R7: With latched bits 2 and 1 both set, `ref_tick` is 1 exactly after edges n with n mod 2048 = 2047, formed as a halving stage followed by a 1024 stage, and `status[4:3]` is 2.
- R8: Mode bit 0 has no effect on `sys_en`, `ref_tick` or `status[4:3]`.
- R9: In either divider mode, `slow_pin` activity has no effect on `ref_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock (crystal domain) |
| rst_n | input | 1 | Synchronous active-low reset; mode pins are sampled while it is low |
| mode_pins | input | 3 | Strap pins: bit 0 selects oscillator or crystal, bit 1 the system rate, bit 2 the reference source group |
| slow_pin | input | 1 | Asynchronous slow external reference |
| sys_en | output | 1 | System clock enable strobe |
| ref_tick | output | 1 | Reference tick strobe |
| status | output | 5 | [2:0] latched mode, [4:3] reference source (0 pin, 1 div1024, 2 div2048) |

## Verification
All eight strap values are applied in turn. After each release the pins are driven to the inverted value, which separates a held latch from one that follows the pins. The slow pin toggles with an irregular 5-high/7-low pattern in every mode. In the pin mode this checks the two-cycle synchroniser latency and single-pulse behaviour. In the divider modes it shows the pin is ignored. Each run lasts past 4096 cycles, so two 2048 periods and several 1024 periods are seen. Comparing mode pairs that differ only in bit 0 shows that bit 0 changes nothing but the status field.

// File: rtl/rcs_pkg.sv
// Shared types for the mode-pin root clock selector.
// Assumes: three strap pins, reference source encoded in two bits.
package rcs_pkg;
    localparam int MODE_W   = 3;
    localparam int SRC_W    = 2;
    localparam int STATUS_W = SRC_W + MODE_W;

    typedef enum logic [SRC_W-1:0] {
        REF_PIN   = 2'd0,
        REF_DIV1K = 2'd1,
        REF_DIV2K = 2'd2
    } ref_src_e;
endpackage

// File: rtl/rcs_mode_latch.sv
// Captures the strap pins while reset is held and decodes the source choice.
// Assumes: straps are stable for at least the final reset cycle.
module rcs_mode_latch
    import rcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_pins,
    output logic [MODE_W-1:0] mode_q,
    output ref_src_e          ref_src
);
    // Sample straps during reset, hold after release.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= mode_pins;
    end

    // Bit 2 picks divider vs pin; bit 1 then picks 1024 vs 2048.
    always_comb begin
        if (!mode_q[2])     ref_src = REF_PIN;
        else if (mode_q[1]) ref_src = REF_DIV2K;
        else                ref_src = REF_DIV1K;
    end

    // R2: latched mode never moves while out of reset.
    assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(mode_q));
endmodule

// File: rtl/rcs_div_chain.sv
// Halving stage plus two power-of-two pulse dividers, all as enables.
// Assumes: a synchronous active-low reset restarts all phases together.
module rcs_div_chain #(
    parameter int DIV_LOG2 = 10
) (
    input  logic clk,
    input  logic rst_n,
    output logic half_pulse,
    output logic div_a_pulse,
    output logic div_b_pulse
);
    localparam logic [DIV_LOG2-1:0] CNT_TOP = {DIV_LOG2{1'b1}};

    logic                half_q;
    logic [DIV_LOG2-1:0] cnt_a;
    logic [DIV_LOG2-1:0] cnt_b;

    // Halving stage toggles every input cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) half_q <= 1'b0;
        else        half_q <= ~half_q;
    end

    // Direct divider counts every input cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_a <= '0;
        else        cnt_a <= cnt_a + 1'b1;
    end

    // Cascaded divider counts only halving-stage pulses.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_b <= '0;
        else if (half_q) cnt_b <= cnt_b + 1'b1;
    end

    assign half_pulse  = half_q;
    assign div_a_pulse = (cnt_a == CNT_TOP);
    assign div_b_pulse = half_q && (cnt_b == CNT_TOP);

    // R7: cascaded pulse only ever lands on a halving-stage pulse.
    assert_cascade_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
        div_b_pulse |=> !half_pulse);
endmodule

// File: rtl/rcs_pin_sync.sv
// Synchronises the slow pin and converts its rising edges to one-cycle ticks.
// Assumes: pin period spans many input cycles.
module rcs_pin_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic tick
);
    logic [SYNC_STAGES:0] chain;

    // Shift the pin through the synchroniser plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[SYNC_STAGES-1:0], pin_in};
    end

    assign tick = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];
endmodule

// File: rtl/rootclk_mode_sel.sv
// Top: selects system rate and reference tick source from latched straps.
// Assumes: all outputs are enables used in the clk domain.
module rootclk_mode_sel
    import rcs_pkg::*;
#(
    parameter int DIV_LOG2    = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [MODE_W-1:0]   mode_pins,
    input  logic                slow_pin,
    output logic                sys_en,
    output logic                ref_tick,
    output logic [STATUS_W-1:0] status
);
    logic [MODE_W-1:0] mode_q;
    ref_src_e          ref_src;
    logic              half_pulse, div_a_pulse, div_b_pulse, pin_tick;

    rcs_mode_latch u_latch (
        .clk(clk), .rst_n(rst_n), .mode_pins(mode_pins),
        .mode_q(mode_q), .ref_src(ref_src)
    );

    rcs_div_chain #(.DIV_LOG2(DIV_LOG2)) u_div (
        .clk(clk), .rst_n(rst_n), .half_pulse(half_pulse),
        .div_a_pulse(div_a_pulse), .div_b_pulse(div_b_pulse)
    );

    rcs_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(slow_pin), .tick(pin_tick)
    );

    // System enable: full rate or halving-stage pulses, silenced in reset.
    assign sys_en = rst_n & (mode_q[1] ? half_pulse : 1'b1);

    // Reference tick mux on the decoded source.
    always_comb begin
        unique case (ref_src)
            REF_DIV1K: ref_tick = rst_n & div_a_pulse;
            REF_DIV2K: ref_tick = rst_n & div_b_pulse;
            default:   ref_tick = rst_n & pin_tick;
        endcase
    end

    assign status = {ref_src, mode_q};

    // R3: full-rate mode keeps the enable high.
    assert_full_rate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q[1] |-> sys_en);
    // R4: half-rate enable never stays high two cycles running.
    assert_half_rate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[1] && sys_en) |=> !sys_en);
    // R5: every reference tick lasts one cycle.
    assert_tick_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ref_tick |=> !ref_tick);
    // R1: no strobes while reset is held.
    assert_quiet_reset_R1: assert property (@(posedge clk)
        !rst_n |-> (!sys_en && !ref_tick));
endmodule

// File: tb/tb_rootclk_mode_sel.sv
`timescale 1ns/1ps
module tb_rootclk_mode_sel;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode_pins = 3'b000;
    logic       slow_pin = 1'b0;
    logic       sys_en, ref_tick;
    logic [4:0] status;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic       in_rst;
        logic       sys;
        logic       tick;
        logic [4:0] st;
        logic [2:0] m;
    } exp_t;
    exp_t sbq[$];

    // Reference model state
    int         n = 0;
    logic [2:0] mm = 3'b000;
    logic       q0 = 1'b0, q1 = 1'b0, q2 = 1'b0;

    always #2.5 clk = ~clk;

    rootclk_mode_sel dut (
        .clk(clk), .rst_n(rst_n), .mode_pins(mode_pins), .slow_pin(slow_pin),
        .sys_en(sys_en), .ref_tick(ref_tick), .status(status)
    );

    function automatic logic [1:0] src_of(input logic [2:0] m);
        return m[2] ? (m[1] ? 2'd2 : 2'd1) : 2'd0;
    endfunction

    // Driver: apply one cycle of stimulus and push the expected outputs.
    task automatic drive_cycle(input logic r, input logic [2:0] pins, input logic pin);
        exp_t e;
        @(negedge clk);
        #1;
        rst_n = r; mode_pins = pins; slow_pin = pin;
        @(posedge clk);
        if (!r) begin
            mm = pins; n = 0; q0 = 0; q1 = 0; q2 = 0;
        end else begin
            n++; q2 = q1; q1 = q0; q0 = pin;
        end
        e.in_rst = !r;
        e.m      = mm;
        e.st     = {src_of(mm), mm};
        if (!r) begin
            e.sys = 1'b0; e.tick = 1'b0;
        end else begin
            e.sys = mm[1] ? ((n % 2) == 1) : 1'b1;
            if (!mm[2])     e.tick = q1 & ~q2;
            else if (mm[1]) e.tick = ((n % 2048) == 2047);
            else            e.tick = ((n % 1024) == 1023);
        end
        sbq.push_back(e);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Monitor: pop expectations and compare away from the active edge.
    always @(negedge clk) begin
        while (sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            if (e.in_rst) begin
                check(sys_en == 1'b0,  "R1 sys_en in reset",   sys_en,   0);
                check(ref_tick == 1'b0, "R1 ref_tick in reset", ref_tick, 0);
                check(status[2:0] == e.m, "R2 mode capture", status[2:0], e.m);
            end else begin
                check(status[2:0] == e.m, "R2 mode held", status[2:0], e.m);
                check(status[4:3] == e.st[4:3], "R8 source code", status[4:3], e.st[4:3]);
                if (e.m[1]) check(sys_en == e.sys, "R4 half-rate enable", sys_en, e.sys);
                else        check(sys_en == e.sys, "R3 full-rate enable", sys_en, e.sys);
                if (!e.m[2])     check(ref_tick == e.tick, "R5 pin tick", ref_tick, e.tick);
                else if (e.m[1]) check(ref_tick == e.tick, "R7 div2048 tick (R9)", ref_tick, e.tick);
                else             check(ref_tick == e.tick, "R6 div1024 tick (R9)", ref_tick, e.tick);
            end
        end
    end

    // Stimulus: every strap value, pins inverted after release.
    initial begin
        for (int m = 0; m < 8; m++) begin
            for (int k = 0; k < 3; k++) drive_cycle(1'b0, 3'(m), 1'b0);
            for (int c = 0; c < 4200; c++)
                drive_cycle(1'b1, ~3'(m), ((c % 12) < 5));
        end
        @(negedge clk);
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule